// File: doc/BRIEF.md
# Sixteen-bit arithmetic and logic unit with carry flag register

This block is the arithmetic and logic unit of a small three-operand load-store processor. Each cycle it takes two operands and an operation code and produces a result word at once, without a clock. It also produces the next values of four condition flags: carry, zero, negative and overflow. The four flags live in a register inside the block. They are loaded on the rising clock edge only when the flag-write enable is high. The stored carry feeds back into the operations that consume it: add with carry, subtract with borrow, and the shift left that fills bit 0 from carry.

The unit also tells the register file whether the result should be written. Compares and the carry-invert operation leave the result register alone. For the two compare operations a `cmp_less` output reports whether A is below B. The signed compare reads this from negative XOR overflow. The unsigned compare reads it from the borrow.

The carry convention suits multi-word arithmetic and shift-and-add routines. Every bitwise operation clears carry. Carry can be inverted on its own. Each shift moves the word by exactly one position and puts the bit pushed out of the word into carry.

Top module: `alu16_core`

## Requirements
- R1: Opcode 0 (add) gives A+B, and opcode 1 (add with carry) gives A+B+C, where C is the stored carry. For both, the next carry is the carry out of bit 15.
- R2: Opcode 2 (subtract) gives A-B, and opcode 3 (subtract with borrow) gives A-B-C. For both, the next carry is 1 exactly when unsigned A is less than B (or less than B+C for opcode 3).
- R3: For opcodes 0, 1, 2, 3, 13 and 14, the next overflow flag is 1 exactly on two's-complement signed overflow of the addition or subtraction.
- R4: Opcodes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOT of A) give the bitwise result and always set the next carry and next overflow to 0.
- R5: Opcode 8 shifts left logically by one position, opcode 9 shifts right logically, and opcode 10 shifts right arithmetically, copying bit 15. The next carry is the bit shifted out: bit 15 for left shifts, bit 0 for right shifts. The next overflow is 0.
- R6: Opcode 11 shifts left by one position, fills bit 0 with the stored carry, and sets the next carry to the old bit 15.
- R7: Opcode 12 inverts the stored carry. It holds zero, negative and overflow, drives a result of 0 and keeps `res_wr` low.
- R8: Opcodes 13 (signed compare) and 14 (unsigned compare) set the flags as a plain subtract A-B would and keep `res_wr` low. `cmp_less` is negative XOR overflow for opcode 13 and the borrow for opcode 14. For every other opcode `cmp_less` is 0.
- R9: Whenever `res_wr` is high, and for both compares, the next zero flag is 1 exactly when the result is 0x0000, and the next negative flag equals result bit 15.
- R10: The flag register loads the next flag values on a rising clock edge only when `flag_we` is high. Otherwise it holds its value.
- R11: A rising clock edge with `rst_n` low clears all four stored flags.
- R12: Opcode 15 is reserved. It drives a result of 0, keeps `res_wr` and `cmp_less` low, and leaves all next flag values equal to the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code, 0 to 15 |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| flag_we | input | 1 | Load the flag register at the next edge |
| result | output | 16 | Result word |
| res_wr | output | 1 | Result should be written to the destination register |
| cmp_less | output | 1 | A below B, valid for the compare opcodes |
| nxt_c | output | 1 | Next carry value |
| nxt_z | output | 1 | Next zero value |
| nxt_n | output | 1 | Next negative value |
| nxt_v | output | 1 | Next overflow value |
| flag_c | output | 1 | Stored carry |
| flag_z | output | 1 | Stored zero |
| flag_n | output | 1 | Stored negative |
| flag_v | output | 1 | Stored overflow |

## Verification
The bench builds the unit with its default word width of 16, the only width the processor uses. At that width, the operands that matter can be written directly: the sign boundary between 0x7FFF and 0x8000, the all-ones word that produces a carry out or a borrow, and words whose shifted-out bit is 1 at either end. Before each operation, every table entry loads the stored carry as 0 or 1 through a preparatory subtract. This lets add with carry, subtract with borrow, the carry-fill shift and the carry invert run with both carry values.

// File: rtl/alu16_pkg.sv
// Shared operation codes and flag type for the 16-bit ALU.
// Assumes a 4-bit operation field; the low two bits pick the variant
// inside the logic group (4..7) and the shift group (8..11).
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_SAR  = 4'd10,
        OP_RLC  = 4'd11,
        OP_CMC  = 4'd12,
        OP_CMPS = 4'd13,
        OP_CMPU = 4'd14,
        OP_RSV  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu16_arith.sv
// Adder/subtractor shared by add, subtract and compare.
// Assumes unsigned borrow convention: cout is 1 when a subtract wraps below zero.
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         do_sub,
    input  logic         use_cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] ext;
    logic       cin_eff;

    // Extended-width add or subtract, carry-in gated by use_cin.
    always_comb begin
        cin_eff = cin & use_cin;
        if (do_sub)
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_eff};
        else
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_eff};
    end

    // Split out result, carry/borrow and signed overflow.
    always_comb begin
        sum  = ext[W-1:0];
        cout = ext[W];
        if (do_sub)
            ovf = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        else
            ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu16_logic.sv
// Bitwise unit: AND, OR, XOR, NOT of A, selected by a 2-bit code.
// Assumes sel order AND=0, OR=1, XOR=2, NOT=3.
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    // Pick the bitwise function.
    always_comb begin
        case (sel)
            2'd0:    res = a & b;
            2'd1:    res = a | b;
            2'd2:    res = a ^ b;
            default: res = ~a;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
// One-position shifter with the bit pushed out reported separately.
// Assumes sel order SHL=0, SHR=1, SAR=2, carry-fill SHL=3.
module alu16_shift #(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         out_bit
);
    // Shift by one and capture the departing bit.
    always_comb begin
        case (sel)
            2'd0: begin
                res     = {a[W-2:0], 1'b0};
                out_bit = a[W-1];
            end
            2'd1: begin
                res     = {1'b0, a[W-1:1]};
                out_bit = a[0];
            end
            2'd2: begin
                res     = {a[W-1], a[W-1:1]};
                out_bit = a[0];
            end
            default: begin
                res     = {a[W-2:0], cin};
                out_bit = a[W-1];
            end
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
// Four-flag condition register, synchronous active-low reset, write enable.
// Assumes reset dominates the enable.
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  alu_flags_t d,
    output alu_flags_t q
);
    // Clear on reset, load on enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/alu16_core.sv
// Top of the 16-bit ALU: combinational result and next flags, registered flags.
// Assumes op_sel is stable during the cycle; the stored carry is the carry input
// for add-with-carry, subtract-with-borrow and the carry-fill shift.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic         res_wr,
    output logic         cmp_less,
    output logic         nxt_c,
    output logic         nxt_z,
    output logic         nxt_n,
    output logic         nxt_v,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v
);
    alu_op_e    op;
    alu_flags_t flg_q, flg_d;
    logic [W-1:0] sum, lres, sres;
    logic         cout, ovf, sout, do_sub, use_cin;

    assign op = alu_op_e'(op_sel);

    // Arithmetic unit control from the operation code.
    always_comb begin
        do_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMPS) || (op == OP_CMPU);
        use_cin = (op == OP_ADC) || (op == OP_SBC);
    end

    alu16_arith #(.W(W)) arith_i (
        .a(opnd_a), .b(opnd_b), .cin(flg_q.c), .do_sub(do_sub),
        .use_cin(use_cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    alu16_logic #(.W(W)) logic_i (
        .sel(op_sel[1:0]), .a(opnd_a), .b(opnd_b), .res(lres)
    );

    alu16_shift #(.W(W)) shift_i (
        .sel(op_sel[1:0]), .a(opnd_a), .cin(flg_q.c), .res(sres), .out_bit(sout)
    );

    // Result mux, write strobe, compare outcome and next flags.
    always_comb begin
        result   = '0;
        res_wr   = 1'b0;
        cmp_less = 1'b0;
        flg_d    = flg_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result  = sum;
                res_wr  = 1'b1;
                flg_d.c = cout;
                flg_d.v = ovf;
                flg_d.z = (sum == '0);
                flg_d.n = sum[W-1];
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                result  = lres;
                res_wr  = 1'b1;
                flg_d.c = 1'b0;
                flg_d.v = 1'b0;
                flg_d.z = (lres == '0);
                flg_d.n = lres[W-1];
            end
            OP_SHL, OP_SHR, OP_SAR, OP_RLC: begin
                result  = sres;
                res_wr  = 1'b1;
                flg_d.c = sout;
                flg_d.v = 1'b0;
                flg_d.z = (sres == '0);
                flg_d.n = sres[W-1];
            end
            OP_CMC: begin
                flg_d.c = ~flg_q.c;
            end
            OP_CMPS, OP_CMPU: begin
                result   = sum;
                flg_d.c  = cout;
                flg_d.v  = ovf;
                flg_d.z  = (sum == '0);
                flg_d.n  = sum[W-1];
                cmp_less = (op == OP_CMPS) ? (sum[W-1] ^ ovf) : cout;
            end
            default: begin
                result = '0;
            end
        endcase
    end

    alu16_flagreg flagreg_i (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flg_d), .q(flg_q)
    );

    // Flatten flag structs onto ports.
    always_comb begin
        {nxt_c, nxt_z, nxt_n, nxt_v}     = flg_d;
        {flag_c, flag_z, flag_n, flag_v} = flg_q;
    end
endmodule

// File: rtl/alu16_core_chk.sv
// Property checker for alu16_core, attached by bind.
// Assumes synchronous active-low reset driven away from the clock edge.
module alu16_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_sel,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic         res_wr,
    input logic         cmp_less,
    input logic         nxt_c,
    input logic         nxt_z,
    input logic         nxt_n,
    input logic         nxt_v,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_v
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({flag_c, flag_z, flag_n, flag_v}));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> {flag_c, flag_z, flag_n, flag_v} == $past({nxt_c, nxt_z, nxt_n, nxt_v}));

    assert_rst_clear_R11: assert property (@(posedge clk)
        !rst_n |=> {flag_c, flag_z, flag_n, flag_v} == 4'b0000);

    assert_logic_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel inside {4'd4, 4'd5, 4'd6, 4'd7}) |-> (!nxt_c && !nxt_v));

    assert_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel inside {4'd12, 4'd13, 4'd14, 4'd15}) |-> !res_wr);

    assert_less_only_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_sel inside {4'd13, 4'd14}) |-> !cmp_less);

    assert_cmc_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd12 && flag_we) |=> flag_c != $past(flag_c));

    assert_zn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> (nxt_z == (result == '0)) && (nxt_n == result[W-1]));

    assert_rsv_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd15) |-> (result == '0) &&
        ({nxt_c, nxt_z, nxt_n, nxt_v} == {flag_c, flag_z, flag_n, flag_v}));
endmodule

bind alu16_core alu16_core_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .flag_we(flag_we),
    .result(result), .res_wr(res_wr), .cmp_less(cmp_less),
    .nxt_c(nxt_c), .nxt_z(nxt_z), .nxt_n(nxt_n), .nxt_v(nxt_v),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
);

// File: tb/alu16_core_tb_top.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module alu16_core_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_sel = 4'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         flag_we = 1'b0;
    logic [W-1:0] result;
    logic         res_wr, cmp_less;
    logic         nxt_c, nxt_z, nxt_n, nxt_v;
    logic         flag_c, flag_z, flag_n, flag_v;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    alu16_core #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_we(flag_we), .result(result), .res_wr(res_wr),
        .cmp_less(cmp_less), .nxt_c(nxt_c), .nxt_z(nxt_z), .nxt_n(nxt_n),
        .nxt_v(nxt_v), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
        .flag_v(flag_v)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
    } vec_t;

    typedef struct packed {
        logic [15:0] res;
        logic        wr;
        logic        less;
        logic [3:0]  f;
    } exp_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0001, 16'h0002, 1'b1},
        '{4'd0,  16'hFFFF, 16'h0001, 1'b0},
        '{4'd0,  16'h7FFF, 16'h0001, 1'b0},
        '{4'd1,  16'h0001, 16'h0001, 1'b1},
        '{4'd1,  16'hFFFF, 16'h0000, 1'b1},
        '{4'd1,  16'h1000, 16'h0234, 1'b0},
        '{4'd2,  16'h0005, 16'h0003, 1'b1},
        '{4'd2,  16'h0003, 16'h0005, 1'b0},
        '{4'd2,  16'h8000, 16'h0001, 1'b0},
        '{4'd3,  16'h0005, 16'h0005, 1'b1},
        '{4'd3,  16'h0000, 16'h0000, 1'b0},
        '{4'd4,  16'hF0F0, 16'hFF00, 1'b1},
        '{4'd5,  16'h1234, 16'h1234, 1'b1},
        '{4'd6,  16'hA5A5, 16'hA5A5, 1'b1},
        '{4'd7,  16'h00FF, 16'h0000, 1'b1},
        '{4'd8,  16'h8001, 16'h0000, 1'b0},
        '{4'd8,  16'h4000, 16'h0000, 1'b1},
        '{4'd9,  16'h8001, 16'h0000, 1'b0},
        '{4'd10, 16'h8002, 16'h0000, 1'b0},
        '{4'd10, 16'h4001, 16'h0000, 1'b0},
        '{4'd11, 16'h8000, 16'h0000, 1'b1},
        '{4'd11, 16'h4000, 16'h0000, 1'b0},
        '{4'd12, 16'h1111, 16'h2222, 1'b0},
        '{4'd12, 16'h1111, 16'h2222, 1'b1},
        '{4'd13, 16'h8000, 16'h0001, 1'b0},
        '{4'd13, 16'h0001, 16'h0002, 1'b1},
        '{4'd13, 16'h0002, 16'h0002, 1'b0},
        '{4'd14, 16'h0001, 16'hFFFF, 1'b0},
        '{4'd14, 16'hFFFF, 16'h0001, 1'b1},
        '{4'd15, 16'hABCD, 16'h1234, 1'b1},
        '{4'd15, 16'h0000, 16'h0000, 1'b0},
        '{4'd6,  16'h0F0F, 16'hF0F0, 1'b1}
    };

    // Reference model written from the requirements; prev is {c,z,n,v}.
    function automatic exp_t model(logic [3:0] op, logic [15:0] a, logic [15:0] b,
                                   logic [3:0] prev);
        exp_t e;
        logic cin;
        logic [16:0] t;
        cin = prev[3];
        e.res = '0; e.wr = 1'b0; e.less = 1'b0; e.f = prev;
        case (op)
            4'd0, 4'd1: begin
                t = {1'b0, a} + {1'b0, b} + {16'b0, (op == 4'd1) & cin};
                e.res = t[15:0]; e.wr = 1'b1; e.f[3] = t[16];
                e.f[0] = (a[15] == b[15]) && (e.res[15] != a[15]);
            end
            4'd2, 4'd3, 4'd13, 4'd14: begin
                t = {16'b0, (op == 4'd3) & cin};
                e.res = a - b - t[15:0];
                e.f[3] = ({1'b0, a} < ({1'b0, b} + t));
                e.f[0] = (a[15] != b[15]) && (e.res[15] != a[15]);
                e.wr = (op <= 4'd3);
                if (op == 4'd13) e.less = ($signed(a) < $signed(b));
                if (op == 4'd14) e.less = (a < b);
            end
            4'd4: begin e.res = a & b; e.wr = 1'b1; e.f[3] = 1'b0; e.f[0] = 1'b0; end
            4'd5: begin e.res = a | b; e.wr = 1'b1; e.f[3] = 1'b0; e.f[0] = 1'b0; end
            4'd6: begin e.res = a ^ b; e.wr = 1'b1; e.f[3] = 1'b0; e.f[0] = 1'b0; end
            4'd7: begin e.res = ~a;    e.wr = 1'b1; e.f[3] = 1'b0; e.f[0] = 1'b0; end
            4'd8:  begin e.res = {a[14:0], 1'b0};  e.wr = 1'b1; e.f[3] = a[15]; e.f[0] = 1'b0; end
            4'd9:  begin e.res = {1'b0, a[15:1]};  e.wr = 1'b1; e.f[3] = a[0];  e.f[0] = 1'b0; end
            4'd10: begin e.res = {a[15], a[15:1]}; e.wr = 1'b1; e.f[3] = a[0];  e.f[0] = 1'b0; end
            4'd11: begin e.res = {a[14:0], cin};   e.wr = 1'b1; e.f[3] = a[15]; e.f[0] = 1'b0; end
            4'd12: e.f[3] = ~cin;
            default: ;
        endcase
        if (e.wr || op == 4'd13 || op == 4'd14) begin
            e.f[2] = (e.res == 16'h0000);
            e.f[1] = e.res[15];
        end
        return e;
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8, 4'd9, 4'd10: return "R5";
            4'd11: return "R6";
            4'd12: return "R7";
            4'd13, 4'd14: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Load stored carry through a subtract 0-cv (flags become known).
    task automatic set_carry(logic cv);
        @(negedge clk);
        op_sel = 4'd2; opnd_a = 16'h0000; opnd_b = {15'b0, cv}; flag_we = 1'b1;
        @(posedge clk);
    endtask

    function automatic logic [3:0] carry_flags(logic cv);
        return cv ? 4'b1010 : 4'b0100;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R11", "flags after reset", {28'b0, flag_c, flag_z, flag_n, flag_v}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            exp_t e;
            string rq;
            set_carry(VECS[i].cin);
            @(negedge clk);
            op_sel = VECS[i].op; opnd_a = VECS[i].a; opnd_b = VECS[i].b; flag_we = 1'b1;
            #1;
            e  = model(VECS[i].op, VECS[i].a, VECS[i].b, carry_flags(VECS[i].cin));
            rq = req_of(VECS[i].op);
            check(rq, "result", {16'b0, result}, {16'b0, e.res});
            check(rq, "res_wr", {31'b0, res_wr}, {31'b0, e.wr});
            check((VECS[i].op == 4'd13 || VECS[i].op == 4'd14) ? "R8" : "R12",
                  "cmp_less", {31'b0, cmp_less}, {31'b0, e.less});
            check("R3", "next overflow", {31'b0, nxt_v}, {31'b0, e.f[0]});
            check("R9", "next zero/negative", {30'b0, nxt_z, nxt_n}, {30'b0, e.f[2:1]});
            check(rq, "next carry", {31'b0, nxt_c}, {31'b0, e.f[3]});
            @(posedge clk);
            @(negedge clk); #1;
            check("R10", "stored flags", {28'b0, flag_c, flag_z, flag_n, flag_v}, {28'b0, e.f});
        end

        // R10: flag_we low holds stored flags while next values differ.
        set_carry(1'b1);
        @(negedge clk);
        op_sel = 4'd4; opnd_a = 16'h0000; opnd_b = 16'h0000; flag_we = 1'b0;
        #1;
        check("R4", "AND next carry", {31'b0, nxt_c}, 32'h0);
        @(posedge clk);
        @(negedge clk); #1;
        check("R10", "flags held with we low", {28'b0, flag_c, flag_z, flag_n, flag_v},
              {28'b0, carry_flags(1'b1)});

        // R11: mid-run reset clears flags that were set.
        set_carry(1'b1);
        @(negedge clk);
        rst_n = 1'b0; flag_we = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        check("R11", "flags after mid-run reset", {28'b0, flag_c, flag_z, flag_n, flag_v}, 32'h0);
        rst_n = 1'b1;

        // R6: carry-fill chain, two shifts feed carry forward.
        set_carry(1'b1);
        @(negedge clk);
        op_sel = 4'd11; opnd_a = 16'h8000; flag_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_sel = 4'd11; opnd_a = 16'h0000; #1;
        check("R6", "carry-fill uses previous shift-out", {16'b0, result}, 32'h0001);
        @(posedge clk);
        @(negedge clk);
        flag_we = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule